// File: doc/BRIEF.md
# Shadow Stack Control Unit

This unit carries out the four shadow-stack operations of one hart: pushing a link register value, popping and checking an entry against a link register, reading the shadow stack pointer, and atomically swapping a word on the shadow stack. The decode stage hands it one operation at a time with the current privilege level, the values of x1 and x5, and the two per-mode enable bits taken from the environment configuration registers. The unit owns the shadow stack pointer, which software also reads and writes as a CSR.

Memory traffic leaves through a simple word-wide request port. Every request is tagged as shadow-stack traffic so that the permission checker can tell it apart from ordinary loads and stores. The request is held until the memory side answers with a done strobe, a read word and a fault flag. Each operation ends with a one-cycle `done` pulse, which may carry a destination register result or an exception with cause and trap value.

When the feature is not active at the current privilege, push, pop-check and read-pointer behave as no-ops and the swap raises an illegal-instruction exception. Compressed may-be-operation numbers 1 and 5 are recognised as push of x1 and pop-check of x5.

Top module: `sstk_unit`

## Requirements
- R1: After a synchronous active-high reset the shadow stack pointer is zero, and `mem_req`, `busy`, `done`, `res_valid` and `exc_valid` are all low.
- R2: CSR address 0x011 reads the shadow stack pointer on `csr_rdata` and a write there loads it. Any other address reads zero, and writes to it leave the pointer unchanged.
- R3: The feature is active in machine mode (`priv`=3) always, in supervisor mode (`priv`=1) when `m_env_ss` (bit 3 of the machine environment configuration) is 1, and in user mode (`priv`=0) only when both `m_env_ss` and `s_env_ss` (bit 3 of the supervisor environment configuration) are 1. `priv`=2 is never active.
- R4: An active push (`op_kind`=0) writes the link value (`op_rsel`=0 selects x1, 1 selects x5) to address pointer−4 with `mem_we`=1. After a fault-free completion the pointer becomes pointer−4.
- R5: An active pop-check (`op_kind`=1) reads address pointer with `mem_we`=0. If the returned word equals the link value, it completes with no exception and the pointer becomes pointer+4.
- R6: A pop-check whose returned word differs from the link value raises exception cause 18 (software check) with trap value 3 and leaves the pointer unchanged.
- R7: A memory fault on any request raises exception cause 7 (store/AMO access fault) with the request address as trap value and leaves the pointer unchanged.
- R8: An active read-pointer (`op_kind`=2) returns the pointer on `res_data` with `res_valid`=1 and issues no memory request.
- R9: When the feature is inactive, push, pop-check and read-pointer complete with no memory request, no result, no exception and no pointer change.
- R10: An inactive swap (`op_kind`=3) raises cause 2 (illegal instruction) with trap value 0. An active swap issues a request with `mem_amo`=1 and `mem_we`=1 to `op_addr` carrying `op_data`, returns the read word as the result, and leaves the pointer unchanged.
- R11: With `op_cmop`=1, `op_mopn`=1 acts as push of x1 and `op_mopn`=5 as pop-check of x5, whatever `op_kind` and `op_rsel` hold. Any other number is a no-op with no request, result or exception.
- R12: Every memory request has `mem_ss`=1.
- R13: An operation without memory traffic raises `done` in the cycle after acceptance. A memory operation holds its request stable until `mem_done` and raises `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered; taken when `busy` is low |
| op_kind | input | 2 | 0 push, 1 pop-check, 2 read pointer, 3 swap |
| op_rsel | input | 1 | Link register select: 0 x1, 1 x5 |
| op_cmop | input | 1 | Operation comes from a compressed may-be-op |
| op_mopn | input | 4 | Compressed may-be-op number |
| op_addr | input | XLEN | Swap address |
| op_data | input | XLEN | Swap store data |
| x1_val | input | XLEN | Value of x1 |
| x5_val | input | XLEN | Value of x5 |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_env_ss | input | 1 | Machine environment configuration bit 3 |
| s_env_ss | input | 1 | Supervisor environment configuration bit 3 |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| busy | output | 1 | A memory operation is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request writes |
| mem_amo | output | 1 | Request is an atomic swap |
| mem_ss | output | 1 | Request is shadow-stack traffic |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Request write data |
| mem_done | input | 1 | Request completed this cycle |
| mem_rdata | input | XLEN | Read word returned with `mem_done` |
| mem_fault | input | 1 | Request faulted, valid with `mem_done` |
| done | output | 1 | Operation finished (one-cycle pulse) |
| res_valid | output | 1 | `res_data` carries a destination result |
| res_data | output | XLEN | Destination result |
| exc_valid | output | 1 | Operation raised an exception |
| exc_cause | output | 6 | Exception cause |
| exc_tval | output | XLEN | Exception trap value |

## Verification
The hardest cases to reach are the ones where the enable chain and the memory response combine: a pop-check that returns a mismatching word, or a push that faults, must both leave the pointer untouched. The bench builds these by programming the pointer through the CSR port and then replying from its memory model with a chosen word or fault flag after a chosen latency. It reads the pointer back through the CSR port after each operation. The enable chain is walked through every privilege and bit combination, including a supervisor bit set under a cleared machine bit. Compressed numbers are issued with conflicting `op_kind` and `op_rsel` values, so that only correct decoding gives the expected address and data.

// File: rtl/sstk_pkg.sv
package sstk_pkg;

    localparam int CAUSE_W = 6;
    localparam logic [11:0] SSP_CSR_ADDR = 12'h011;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 6'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT = 6'd7;
    localparam logic [CAUSE_W-1:0] CAUSE_SWCHECK = 6'd18;
    localparam int SWCHK_TVAL_SS = 3;

    localparam logic [3:0] CMOP_PUSH_X1 = 4'd1;
    localparam logic [3:0] CMOP_POP_X5 = 4'd5;

    typedef enum logic [1:0] {
        KIND_PUSH = 2'd0,
        KIND_POPC = 2'd1,
        KIND_RDSP = 2'd2,
        KIND_SWAP = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        SOP_NOP,
        SOP_PUSH,
        SOP_POPC,
        SOP_RDSP,
        SOP_SWAP
    } sop_e;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_H = 2'd2,
        PRV_M = 2'd3
    } prv_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } st_e;

    function automatic logic ss_active(input logic [1:0] p, input logic m_en, input logic s_en);
        case (prv_e'(p))
            PRV_M:   return 1'b1;
            PRV_S:   return m_en;
            PRV_U:   return m_en & s_en;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sstk_mode_gate.sv
module sstk_mode_gate
    import sstk_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       m_env_ss,
    input  logic       s_env_ss,
    output logic       active
);
    assign active = ss_active(priv, m_env_ss, s_env_ss);
endmodule

// File: rtl/sstk_op_decode.sv
module sstk_op_decode
    import sstk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op_kind,
    input  logic            op_rsel,
    input  logic            op_cmop,
    input  logic [3:0]      op_mopn,
    input  logic [XLEN-1:0] x1_val,
    input  logic [XLEN-1:0] x5_val,
    output sop_e            sop,
    output logic [XLEN-1:0] link
);
    always_comb begin
        sop  = SOP_NOP;
        link = op_rsel ? x5_val : x1_val;
        if (op_cmop) begin
            if (op_mopn == CMOP_PUSH_X1) begin
                sop  = SOP_PUSH;
                link = x1_val;
            end else if (op_mopn == CMOP_POP_X5) begin
                sop  = SOP_POPC;
                link = x5_val;
            end
        end else begin
            case (kind_e'(op_kind))
                KIND_PUSH: sop = SOP_PUSH;
                KIND_POPC: sop = SOP_POPC;
                KIND_RDSP: sop = SOP_RDSP;
                default:   sop = SOP_SWAP;
            endcase
        end
    end
endmodule

// File: rtl/sstk_ptr_reg.sv
module sstk_ptr_reg
    import sstk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit_en,
    input  logic [XLEN-1:0] commit_val,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] ssp
);
    logic hit;
    assign hit = (csr_addr == SSP_CSR_ADDR);

    // An operation's own pointer update wins over a CSR write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ssp <= '0;
        end else if (commit_en) begin
            ssp <= commit_val;
        end else if (csr_we && hit) begin
            ssp <= csr_wdata;
        end
    end

    assign csr_rdata = hit ? ssp : '0;
endmodule

// File: rtl/sstk_unit.sv
module sstk_unit
    import sstk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [1:0]         op_kind,
    input  logic               op_rsel,
    input  logic               op_cmop,
    input  logic [3:0]         op_mopn,
    input  logic [XLEN-1:0]    op_addr,
    input  logic [XLEN-1:0]    op_data,
    input  logic [XLEN-1:0]    x1_val,
    input  logic [XLEN-1:0]    x5_val,
    input  logic [1:0]         priv,
    input  logic               m_env_ss,
    input  logic               s_env_ss,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_amo,
    output logic               mem_ss,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic               mem_done,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_fault,
    output logic               done,
    output logic               res_valid,
    output logic [XLEN-1:0]    res_data,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_tval
);
    localparam int WBYTES = XLEN / 8;
    localparam logic [XLEN-1:0] STEP = XLEN'(WBYTES);

    logic            active;
    sop_e            dec_sop;
    logic [XLEN-1:0] dec_link;
    logic [XLEN-1:0] ssp_q;
    logic            commit_en;
    logic [XLEN-1:0] commit_val;

    st_e             state;
    sop_e            cur_sop;
    logic [XLEN-1:0] cur_link;

    sstk_mode_gate u_gate (
        .priv     (priv),
        .m_env_ss (m_env_ss),
        .s_env_ss (s_env_ss),
        .active   (active)
    );

    sstk_op_decode #(.XLEN(XLEN)) u_dec (
        .op_kind (op_kind),
        .op_rsel (op_rsel),
        .op_cmop (op_cmop),
        .op_mopn (op_mopn),
        .x1_val  (x1_val),
        .x5_val  (x5_val),
        .sop     (dec_sop),
        .link    (dec_link)
    );

    sstk_ptr_reg #(.XLEN(XLEN)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .commit_en  (commit_en),
        .commit_val (commit_val),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .ssp        (ssp_q)
    );

    logic rsp_ok;
    logic pop_match;
    assign rsp_ok    = (state == ST_WAIT) && mem_done && !mem_fault;
    assign pop_match = (mem_rdata == cur_link);

    // Pointer moves only on a fault-free completion; a pop also needs a match.
    always_comb begin
        commit_en  = 1'b0;
        commit_val = mem_addr;
        if (rsp_ok && cur_sop == SOP_PUSH) begin
            commit_en = 1'b1;
        end else if (rsp_ok && cur_sop == SOP_POPC && pop_match) begin
            commit_en  = 1'b1;
            commit_val = mem_addr + STEP;
        end
    end

    assign busy   = (state == ST_WAIT);
    assign mem_ss = mem_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_sop   <= SOP_NOP;
            cur_link  <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_amo   <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            exc_valid <= 1'b0;
            exc_cause <= '0;
            exc_tval  <= '0;
        end else begin
            done      <= 1'b0;
            res_valid <= 1'b0;
            exc_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (op_valid) begin
                        cur_sop  <= dec_sop;
                        cur_link <= dec_link;
                        if (!active || dec_sop == SOP_NOP) begin
                            done <= 1'b1;
                            if (dec_sop == SOP_SWAP) begin
                                exc_valid <= 1'b1;
                                exc_cause <= CAUSE_ILLEGAL;
                                exc_tval  <= '0;
                            end
                        end else if (dec_sop == SOP_RDSP) begin
                            done      <= 1'b1;
                            res_valid <= 1'b1;
                            res_data  <= ssp_q;
                        end else begin
                            state   <= ST_WAIT;
                            mem_req <= 1'b1;
                            mem_we  <= (dec_sop != SOP_POPC);
                            mem_amo <= (dec_sop == SOP_SWAP);
                            case (dec_sop)
                                SOP_PUSH: begin
                                    mem_addr  <= ssp_q - STEP;
                                    mem_wdata <= dec_link;
                                end
                                SOP_POPC: begin
                                    mem_addr  <= ssp_q;
                                    mem_wdata <= '0;
                                end
                                default: begin
                                    mem_addr  <= op_addr;
                                    mem_wdata <= op_data;
                                end
                            endcase
                        end
                    end
                end
                default: begin
                    if (mem_done) begin
                        state   <= ST_IDLE;
                        mem_req <= 1'b0;
                        done    <= 1'b1;
                        if (mem_fault) begin
                            exc_valid <= 1'b1;
                            exc_cause <= CAUSE_ST_FAULT;
                            exc_tval  <= mem_addr;
                        end else if (cur_sop == SOP_POPC && !pop_match) begin
                            exc_valid <= 1'b1;
                            exc_cause <= CAUSE_SWCHECK;
                            exc_tval  <= XLEN'(SWCHK_TVAL_SS);
                        end else if (cur_sop == SOP_SWAP) begin
                            res_valid <= 1'b1;
                            res_data  <= mem_rdata;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sstk_unit_chk.sv
module sstk_unit_chk
    import sstk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               csr_we,
    input logic               mem_req,
    input logic               mem_ss,
    input logic [XLEN-1:0]    mem_addr,
    input logic [XLEN-1:0]    mem_wdata,
    input logic               mem_done,
    input logic               done,
    input logic               res_valid,
    input logic               exc_valid,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic [XLEN-1:0]    exc_tval,
    input logic [XLEN-1:0]    ssp_q
);
    AST_SS_TAGGED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_ss); // R12

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R13

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_done) |=> (done && !mem_req)); // R13

    AST_SWCHK_TVAL: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_cause == CAUSE_SWCHECK) |-> (exc_tval == XLEN'(SWCHK_TVAL_SS))); // R6

    AST_EXC_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !$past(csr_we)) |-> $stable(ssp_q)); // R7

    AST_EXC_NO_RES: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (done && !res_valid)); // R10
endmodule

bind sstk_unit sstk_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .mem_req   (mem_req),
    .mem_ss    (mem_ss),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done),
    .done      (done),
    .res_valid (res_valid),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .exc_tval  (exc_tval),
    .ssp_q     (ssp_q)
);

// File: tb/sim_sstk_unit.sv
`timescale 1ns/1ps
module sim_sstk_unit;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            op_valid = 0;
    logic [1:0]      op_kind = 0;
    logic            op_rsel = 0;
    logic            op_cmop = 0;
    logic [3:0]      op_mopn = 0;
    logic [XLEN-1:0] op_addr = 0, op_data = 0, x1_val = 0, x5_val = 0;
    logic [1:0]      priv = 2'd3;
    logic            m_env_ss = 0, s_env_ss = 0;
    logic            csr_we = 0;
    logic [11:0]     csr_addr = 12'h011;
    logic [XLEN-1:0] csr_wdata = 0;
    logic [XLEN-1:0] csr_rdata;
    logic            busy, mem_req, mem_we, mem_amo, mem_ss;
    logic [XLEN-1:0] mem_addr, mem_wdata;
    logic            mem_done = 0;
    logic [XLEN-1:0] mem_rdata = 0;
    logic            mem_fault = 0;
    logic            done, res_valid, exc_valid;
    logic [XLEN-1:0] res_data, exc_tval;
    logic [5:0]      exc_cause;

    sstk_unit #(.XLEN(XLEN)) u0 (.*);

    int nchk = 0, nerr = 0;
    int mem_lat = 0;
    logic [XLEN-1:0] mem_rd = 0;
    logic mem_flt = 0;
    int wait_cnt = 0, req_cnt = 0;
    logic [XLEN-1:0] lg_addr, lg_wdata;
    logic lg_we, lg_amo, lg_ss;
    logic g_rv, g_ev;
    logic [XLEN-1:0] g_rd, g_et;
    logic [5:0] g_ec;
    int cyc;

    // Memory model: answers a held request after mem_lat cycles.
    always @(negedge clk) begin
        mem_done = 1'b0;
        if (mem_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_done  = 1'b1;
                mem_rdata = mem_rd;
                mem_fault = mem_flt;
                lg_addr = mem_addr; lg_wdata = mem_wdata;
                lg_we = mem_we; lg_amo = mem_amo; lg_ss = mem_ss;
                req_cnt++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_we = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 0; csr_addr = 12'h011;
    endtask

    task automatic csr_read(input logic [11:0] a, output logic [XLEN-1:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
        csr_addr = 12'h011;
    endtask

    task automatic run_op(input logic [1:0] k, input logic rs, input logic cm, input logic [3:0] mn);
        @(negedge clk);
        op_valid = 1; op_kind = k; op_rsel = rs; op_cmop = cm; op_mopn = mn;
        @(negedge clk);
        op_valid = 0; op_cmop = 0;
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk(0, "R13 operation timeout", 0, 1);
        g_rv = res_valid; g_rd = res_data; g_ev = exc_valid; g_ec = exc_cause; g_et = exc_tval;
    endtask

    task automatic t_reset;
        logic [XLEN-1:0] v;
        chk(!mem_req && !busy && !done && !res_valid && !exc_valid, "R1 idle outputs", {mem_req, busy, done}, 0);
        csr_read(12'h011, v);
        chk(v == 0, "R1 pointer reset", v, 0);
    endtask

    task automatic t_csr;
        logic [XLEN-1:0] v;
        csr_write(12'h011, 32'h1000);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R2 pointer write/read", v, 32'h1000);
        csr_write(12'h012, 32'hDEAD);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R2 other address write ignored", v, 32'h1000);
        csr_read(12'h012, v);
        chk(v == 0, "R2 other address reads zero", v, 0);
    endtask

    task automatic t_push_m;
        logic [XLEN-1:0] v;
        int rc;
        priv = 2'd3; m_env_ss = 0; s_env_ss = 0;
        x5_val = 32'hCAFE0005; x1_val = 32'h11110001;
        mem_lat = 2; mem_flt = 0; rc = req_cnt;
        run_op(2'd0, 1'b1, 1'b0, 4'd0);
        chk(req_cnt == rc + 1 && lg_we && !lg_amo, "R4 push issues write", {lg_we, lg_amo}, 2'b10);
        chk(lg_addr == 32'h0FFC, "R4 push address", lg_addr, 32'h0FFC);
        chk(lg_wdata == 32'hCAFE0005, "R4 push data x5", lg_wdata, 32'hCAFE0005);
        chk(lg_ss, "R12 shadow-stack tag", lg_ss, 1);
        chk(!g_ev, "R4 no exception", g_ev, 0);
        chk(cyc == 4, "R13 done after response lat2", cyc, 4);
        csr_read(12'h011, v);
        chk(v == 32'h0FFC, "R4 pointer decremented", v, 32'h0FFC);
    endtask

    task automatic t_rdsp;
        int rc;
        rc = req_cnt;
        run_op(2'd2, 1'b0, 1'b0, 4'd0);
        chk(g_rv && g_rd == 32'h0FFC, "R8 read pointer result", g_rd, 32'h0FFC);
        chk(req_cnt == rc, "R8 no memory request", req_cnt - rc, 0);
        chk(cyc == 1, "R13 non-memory done next cycle", cyc, 1);
    endtask

    task automatic t_pop_ok;
        logic [XLEN-1:0] v;
        mem_lat = 0; mem_rd = 32'hCAFE0005;
        run_op(2'd1, 1'b1, 1'b0, 4'd0);
        chk(!lg_we && lg_addr == 32'h0FFC, "R5 pop reads at pointer", lg_addr, 32'h0FFC);
        chk(!g_ev && !g_rv, "R5 match no exception", g_ev, 0);
        chk(cyc == 2, "R13 done after response lat0", cyc, 2);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R5 pointer incremented", v, 32'h1000);
    endtask

    task automatic t_pop_bad;
        logic [XLEN-1:0] v;
        mem_lat = 1; mem_rd = 32'h1234; x1_val = 32'h5678;
        run_op(2'd1, 1'b0, 1'b0, 4'd0);
        chk(g_ev && g_ec == 6'd18, "R6 mismatch cause", g_ec, 18);
        chk(g_et == 3, "R6 mismatch tval", g_et, 3);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R6 pointer unchanged", v, 32'h1000);
    endtask

    task automatic t_fault;
        logic [XLEN-1:0] v;
        mem_lat = 1; mem_flt = 1;
        run_op(2'd0, 1'b0, 1'b0, 4'd0);
        mem_flt = 0;
        chk(g_ev && g_ec == 6'd7, "R7 fault cause", g_ec, 7);
        chk(g_et == 32'h0FFC, "R7 fault tval", g_et, 32'h0FFC);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R7 pointer unchanged", v, 32'h1000);
    endtask

    task automatic t_chain;
        logic [XLEN-1:0] v;
        int rc;
        priv = 2'd1; m_env_ss = 0; s_env_ss = 1; rc = req_cnt;
        run_op(2'd0, 1'b0, 1'b0, 4'd0);
        chk(req_cnt == rc && !g_ev && !g_rv, "R9 disabled push is no-op", req_cnt - rc, 0);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R9 disabled push pointer", v, 32'h1000);
        run_op(2'd1, 1'b0, 1'b0, 4'd0);
        chk(req_cnt == rc && !g_ev, "R9 disabled pop is no-op", req_cnt - rc, 0);
        m_env_ss = 1; mem_lat = 0; x1_val = 32'h77;
        run_op(2'd0, 1'b0, 1'b0, 4'd0);
        csr_read(12'h011, v);
        chk(req_cnt == rc + 1 && v == 32'h0FFC, "R3 supervisor enabled by machine bit", v, 32'h0FFC);
        priv = 2'd0; m_env_ss = 1; s_env_ss = 0;
        run_op(2'd2, 1'b0, 1'b0, 4'd0);
        chk(!g_rv && !g_ev, "R3 user needs supervisor bit", g_rv, 0);
        s_env_ss = 1;
        run_op(2'd2, 1'b0, 1'b0, 4'd0);
        chk(g_rv && g_rd == 32'h0FFC, "R3 user enabled by both bits", g_rd, 32'h0FFC);
        m_env_ss = 0;
        run_op(2'd3, 1'b0, 1'b0, 4'd0);
        chk(g_ev && g_ec == 6'd2 && g_et == 0, "R10 disabled swap illegal", g_ec, 2);
        priv = 2'd2; m_env_ss = 1; s_env_ss = 1;
        run_op(2'd2, 1'b0, 1'b0, 4'd0);
        chk(!g_rv, "R3 privilege 2 inactive", g_rv, 0);
        csr_write(12'h011, 32'h1000);
    endtask

    task automatic t_swap;
        logic [XLEN-1:0] v;
        priv = 2'd3; op_addr = 32'h2000; op_data = 32'hAA; mem_rd = 32'h55; mem_lat = 3;
        run_op(2'd3, 1'b0, 1'b0, 4'd0);
        chk(lg_amo && lg_we && lg_addr == 32'h2000, "R10 swap request", lg_addr, 32'h2000);
        chk(lg_wdata == 32'hAA, "R10 swap data", lg_wdata, 32'hAA);
        chk(g_rv && g_rd == 32'h55 && !g_ev, "R10 swap result", g_rd, 32'h55);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R10 swap keeps pointer", v, 32'h1000);
    endtask

    task automatic t_cmop;
        logic [XLEN-1:0] v;
        int rc;
        priv = 2'd3; x1_val = 32'h111; x5_val = 32'h555; mem_lat = 0;
        run_op(2'd3, 1'b1, 1'b1, 4'd1);
        chk(lg_we && !lg_amo && lg_addr == 32'h0FFC && lg_wdata == 32'h111, "R11 cmop1 push x1", lg_wdata, 32'h111);
        mem_rd = 32'h555;
        run_op(2'd2, 1'b0, 1'b1, 4'd5);
        chk(!lg_we && lg_addr == 32'h0FFC && !g_ev, "R11 cmop5 pop x5", g_ec, 0);
        csr_read(12'h011, v);
        chk(v == 32'h1000, "R11 cmop pair restores pointer", v, 32'h1000);
        rc = req_cnt;
        run_op(2'd0, 1'b0, 1'b1, 4'd3);
        chk(req_cnt == rc && !g_ev && !g_rv && cyc == 1, "R11 other cmop is no-op", req_cnt - rc, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_csr();
        t_push_m();
        t_rdsp();
        t_pop_ok();
        t_pop_bad();
        t_fault();
        t_chain();
        t_swap();
        t_cmop();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule